// File: doc/BRIEF.md
# Hiccup Overcurrent Fault Supervisor

This block is the digital supervisor of a power controller with two switching channels and two linear channels. Each analog comparator reaches it as a one-bit level: overcurrent on either switching channel, undervoltage on either linear channel, overvoltage on output 1, "soft-start charged" flags for both soft-start capacitors, and a "shared soft-start discharged" flag. The block drives the inhibit of outputs 1 to 3, the fast discharge of the first soft-start capacitor and the slow discharge of the shared one. It also holds a retry latch, a permanent shutdown latch and a saturating retry counter.

An overcurrent inhibits the outputs and starts a hiccup cycle. The shared soft-start discharges, and once it is low the retry latch clears and a new ramp begins. If a fault hits during a ramp, the outputs are inhibited at once. The discharge and the count are held back until the ramp reaches its charged level. The third counted event latches a shutdown. Only an active-low power-on reset clears that shutdown. Linear undervoltage is ignored until the channel's own soft-start is charged. Channel 3 then enters the retry path, and channel 4 shuts down at once. An overvoltage on output 1 also shuts down and turns the lower switch on.

Top module: `hiccup_fault_sup`

## Requirements
- R1: A high level on either switching overcurrent input (no shutdown, retry latch clear) sets the retry latch. `inhibit_out` and `ss13_fast_dis` follow it high.
- R2: If the shared soft-start is charged when the retry latch is set, `ss24_slow_dis` goes high at once and the retry count rises by one.
- R3: If the shared soft-start is not charged when the retry latch is set, `ss24_slow_dis` stays low and the count holds. When the charged flag rises, the slow discharge starts and the count rises by one.
- R4: The retry latch clears when the discharged flag is high, but only while the slow discharge is running and no shutdown is latched. A discharged flag while the count is still pending has no effect.
- R5: When the count reaches 3, the shutdown latch sets in the same cycle. After that the count stays at 3.
- R6: While the shutdown latch is set, `inhibit_out`, `ss13_fast_dis` and `ss24_slow_dis` stay high and the retry latch stays set, whatever the inputs do.
- R7: Channel 3 undervoltage has no effect while `ss13_chg` is low. With `ss13_chg` high, it acts as an overcurrent (retry path).
- R8: Channel 4 undervoltage has no effect while `ss24_chg` is low. With `ss24_chg` high, it sets the shutdown latch directly and leaves the count unchanged.
- R9: Output 1 overvoltage sets the shutdown latch. `low_sw_on` follows the overvoltage input, while the shutdown stays latched after the input falls.
- R10: While `por_n` is low, and after it is released, every output is 0 and the count is 0.
- R11: Each input passes two synchronizer stages and one state register. A change made before a rising edge shows at the outputs after the third rising edge and not before.

Output encodings: `retry_cnt` is the binary count 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| oc_sw1 | input | 1 | Switching channel 1 overcurrent comparator |
| oc_sw2 | input | 1 | Switching channel 2 overcurrent comparator |
| ss13_chg | input | 1 | First soft-start above upper threshold |
| ss24_chg | input | 1 | Shared soft-start above upper threshold |
| ss24_dis | input | 1 | Shared soft-start below low threshold |
| uv_lin3 | input | 1 | Linear channel 3 undervoltage comparator |
| uv_lin4 | input | 1 | Linear channel 4 undervoltage comparator |
| ov_out1 | input | 1 | Output 1 overvoltage comparator |
| inhibit_out | output | 1 | Inhibit outputs 1, 2 and 3 |
| ss13_fast_dis | output | 1 | Fast discharge of first soft-start |
| ss24_slow_dis | output | 1 | Slow discharge of shared soft-start |
| oc_latch | output | 1 | Retry (overcurrent) latch |
| fault_latch | output | 1 | Permanent shutdown latch |
| retry_cnt | output | 2 | Saturating retry count |
| low_sw_on | output | 1 | Lower switch on command |

## Verification
Every result is due three rising edges after an input change: two synchronizer stages, then the state register. The outputs are decoded from state with no further delay. The vector walk changes inputs on a falling edge and samples four full cycles later, so each result has settled and cannot race the edge. A directed test pins the latency down exactly. It drives an overcurrent and requires the inhibit low after the second rising edge and high after the third.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
  typedef struct packed {
    logic ov1;
    logic uv4;
    logic uv3;
    logic ss24_dis;
    logic ss24_chg;
    logic ss13_chg;
    logic oc2;
    logic oc1;
  } cmp_t;

  localparam int CMP_W = $bits(cmp_t);
endpackage

// File: rtl/hfs_rst_sync.sv
module hfs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/hfs_sync_bank.sv
module hfs_sync_bank #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    logic [WIDTH-1:0] r;
    logic [WIDTH-1:0] r_in;
    if (g == 0) begin : g_first
      assign r_in = d;
    end else begin : g_next
      assign r_in = g_stg[g-1].r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else        r <= r_in;
    end
  end

  assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/hfs_retry_core.sv
module hfs_retry_core
  import hfs_pkg::*;
#(
  parameter int RETRY_LIMIT = 3,
  parameter int CNT_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmp_t             s,
  output logic             oc_q,
  output logic             pend_q,
  output logic             fault_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             low_q
);
  localparam logic [CNT_W-1:0] LIM      = CNT_W'(RETRY_LIMIT);
  localparam logic [CNT_W-1:0] LIM_M1   = CNT_W'(RETRY_LIMIT - 1);

  logic             trig, cnt_evt, cnt_en;
  logic             oc_d, pend_d, fault_d, low_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    trig    = ~oc_q & ~fault_q & (s.oc1 | s.oc2 | (s.uv3 & s.ss13_chg));
    cnt_evt = ~fault_q & s.ss24_chg & (trig | pend_q);
    cnt_en  = cnt_evt & (cnt_q != LIM);
    oc_d    = oc_q;
    pend_d  = pend_q;
    fault_d = fault_q;
    cnt_d   = cnt_q;
    if (trig) begin
      oc_d   = 1'b1;
      pend_d = ~s.ss24_chg;
    end else if (pend_q & s.ss24_chg) begin
      pend_d = 1'b0;
    end else if (oc_q & ~pend_q & ~fault_q & s.ss24_dis) begin
      oc_d = 1'b0;
    end
    if (cnt_en) cnt_d = cnt_q + 1'b1;
    if (cnt_evt && cnt_q == LIM_M1) fault_d = 1'b1;
    if ((s.uv4 & s.ss24_chg) | s.ov1) fault_d = 1'b1;
    low_d = s.ov1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q    <= 1'b0;
      pend_q  <= 1'b0;
      fault_q <= 1'b0;
      low_q   <= 1'b0;
    end else begin
      oc_q    <= oc_d;
      pend_q  <= pend_d;
      fault_q <= fault_d;
      low_q   <= low_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hiccup_fault_sup.sv
module hiccup_fault_sup
  import hfs_pkg::*;
#(
  parameter  int SYNC_STAGES = 2,
  parameter  int RETRY_LIMIT = 3,
  localparam int CNT_W       = $clog2(RETRY_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             oc_sw1,
  input  logic             oc_sw2,
  input  logic             ss13_chg,
  input  logic             ss24_chg,
  input  logic             ss24_dis,
  input  logic             uv_lin3,
  input  logic             uv_lin4,
  input  logic             ov_out1,
  output logic             inhibit_out,
  output logic             ss13_fast_dis,
  output logic             ss24_slow_dis,
  output logic             oc_latch,
  output logic             fault_latch,
  output logic [CNT_W-1:0] retry_cnt,
  output logic             low_sw_on
);
  logic rst_i_n;
  cmp_t raw, syn;
  logic oc_q, pend_q, fault_q, low_q;

  assign raw.ov1      = ov_out1;
  assign raw.uv4      = uv_lin4;
  assign raw.uv3      = uv_lin3;
  assign raw.ss24_dis = ss24_dis;
  assign raw.ss24_chg = ss24_chg;
  assign raw.ss13_chg = ss13_chg;
  assign raw.oc2      = oc_sw2;
  assign raw.oc1      = oc_sw1;

  hfs_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .arst_n(por_n), .rst_n_o(rst_i_n)
  );

  hfs_sync_bank #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_i_n), .d(raw), .q(syn)
  );

  hfs_retry_core #(.RETRY_LIMIT(RETRY_LIMIT), .CNT_W(CNT_W)) i_core (
    .clk(clk), .rst_n(rst_i_n), .s(syn),
    .oc_q(oc_q), .pend_q(pend_q), .fault_q(fault_q),
    .cnt_q(retry_cnt), .low_q(low_q)
  );

  assign inhibit_out   = oc_q | fault_q;
  assign ss13_fast_dis = oc_q | fault_q;
  assign ss24_slow_dis = (oc_q & ~pend_q) | fault_q;
  assign oc_latch      = oc_q;
  assign fault_latch   = fault_q;
  assign low_sw_on     = low_q;
endmodule

// File: rtl/hfs_checker.sv
module hfs_checker #(
  parameter  int RETRY_LIMIT = 3,
  localparam int CNT_W       = $clog2(RETRY_LIMIT + 1)
) (
  input logic             clk,
  input logic             por_n,
  input logic             inhibit_out,
  input logic             ss13_fast_dis,
  input logic             ss24_slow_dis,
  input logic             oc_latch,
  input logic             fault_latch,
  input logic [CNT_W-1:0] retry_cnt,
  input logic             low_sw_on
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(RETRY_LIMIT);

  p_oc_inhibit_r1: assert property (@(posedge clk) disable iff (!por_n)
    oc_latch |-> (inhibit_out && ss13_fast_dis));

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!por_n)
    (retry_cnt != $past(retry_cnt)) |-> (retry_cnt == CNT_W'($past(retry_cnt) + 1'b1)));

  p_clear_after_dis_r4: assert property (@(posedge clk) disable iff (!por_n)
    $fell(oc_latch) |-> $past(ss24_slow_dis));

  p_fault_at_limit_r5: assert property (@(posedge clk) disable iff (!por_n)
    (retry_cnt == LIM) |-> fault_latch);

  p_cnt_sat_r5: assert property (@(posedge clk) disable iff (!por_n)
    (retry_cnt == LIM) |=> (retry_cnt == LIM));

  p_fault_sticky_r6: assert property (@(posedge clk) disable iff (!por_n)
    fault_latch |=> fault_latch);

  p_fault_outputs_r6: assert property (@(posedge clk) disable iff (!por_n)
    fault_latch |-> (inhibit_out && ss13_fast_dis && ss24_slow_dis));

  p_low_sw_fault_r9: assert property (@(posedge clk) disable iff (!por_n)
    low_sw_on |-> fault_latch);
endmodule

bind hiccup_fault_sup hfs_checker i_chk (
  .clk(clk), .por_n(por_n), .inhibit_out(inhibit_out),
  .ss13_fast_dis(ss13_fast_dis), .ss24_slow_dis(ss24_slow_dis),
  .oc_latch(oc_latch), .fault_latch(fault_latch),
  .retry_cnt(retry_cnt), .low_sw_on(low_sw_on)
);

// File: tb/test_hiccup_fault_sup.sv
module test_hiccup_fault_sup;
  logic clk = 1'b0;
  logic por_n;
  logic oc_sw1, oc_sw2, ss13_chg, ss24_chg, ss24_dis, uv_lin3, uv_lin4, ov_out1;
  logic inhibit_out, ss13_fast_dis, ss24_slow_dis, oc_latch, fault_latch, low_sw_on;
  logic [1:0] retry_cnt;
  int total = 0;
  int bad   = 0;
  logic [7:0] obs;

  always #2 clk = ~clk;

  hiccup_fault_sup i_hiccup_fault_sup (
    .clk(clk), .por_n(por_n), .oc_sw1(oc_sw1), .oc_sw2(oc_sw2),
    .ss13_chg(ss13_chg), .ss24_chg(ss24_chg), .ss24_dis(ss24_dis),
    .uv_lin3(uv_lin3), .uv_lin4(uv_lin4), .ov_out1(ov_out1),
    .inhibit_out(inhibit_out), .ss13_fast_dis(ss13_fast_dis),
    .ss24_slow_dis(ss24_slow_dis), .oc_latch(oc_latch),
    .fault_latch(fault_latch), .retry_cnt(retry_cnt), .low_sw_on(low_sw_on)
  );

  // observed pack {low_sw, fault, oc, slow, fast, inhibit, cnt[1:0]}
  assign obs = {low_sw_on, fault_latch, oc_latch, ss24_slow_dis,
                ss13_fast_dis, inhibit_out, retry_cnt};

  // input pack {ov1, uv4, uv3, ss24_dis, ss24_chg, ss13_chg, oc2, oc1}
  localparam logic [15:0] VEC [15] = '{
    {8'b0000_1100, 8'b0000_0000},  // running, nothing set (R1)
    {8'b0000_1101, 8'b0011_1101},  // oc1, charged: count 1, slow on (R1, R2)
    {8'b0000_0000, 8'b0011_1101},  // discharging, latch held (R2)
    {8'b0001_0000, 8'b0000_0001},  // discharged: latch clears (R4)
    {8'b0000_0000, 8'b0000_0001},  // ramping
    {8'b0000_0010, 8'b0010_1101},  // oc2 during ramp: count deferred (R3)
    {8'b0000_0000, 8'b0010_1101},  // still pending (R3)
    {8'b0001_0000, 8'b0010_1101},  // discharged flag while pending ignored (R4)
    {8'b0000_1000, 8'b0011_1110},  // charged: count 2, slow on (R3)
    {8'b0001_0000, 8'b0000_0010},  // discharged: clears (R4)
    {8'b0010_0000, 8'b0000_0010},  // uv3 blanked by ss13 flag (R7)
    {8'b0010_0100, 8'b0010_1110},  // uv3 unblanked: retry path (R7)
    {8'b0000_1000, 8'b0111_1111},  // count 3 sets shutdown (R5)
    {8'b0001_0000, 8'b0111_1111},  // shutdown holds, no clear (R6)
    {8'b0000_0001, 8'b0111_1111}   // oc while shut down: no change (R5, R6)
  };

  task automatic drive(input logic [7:0] v);
    {ov_out1, uv_lin4, uv_lin3, ss24_dis, ss24_chg, ss13_chg, oc_sw2, oc_sw1} = v;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    por_n = 1'b0;
    drive(8'h00);
    repeat (3) @(negedge clk);
    check("R10 in reset", obs, 8'h00);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 after reset", obs, 8'h00);
  endtask

  task automatic apply(input logic [7:0] v);
    @(negedge clk);
    drive(v);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #80000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    por_n = 1'b0;
    drive(8'h00);
    do_reset();

    for (int i = 0; i < 15; i++) begin
      apply(VEC[i][15:8]);
      check($sformatf("R-table step %0d", i), obs, VEC[i][7:0]);
    end

    // R10: reset clears shutdown and count
    do_reset();

    // R11: exact latency, inhibit after the third rising edge
    apply(8'b0000_1100);
    @(negedge clk);
    oc_sw2 = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R11 early", {7'b0, inhibit_out}, 8'h00);
    @(posedge clk);
    #1;
    check("R11 due", {7'b0, inhibit_out}, 8'h01);

    // R8: uv4 blanked, then direct shutdown without count
    do_reset();
    apply(8'b0100_0000);
    check("R8 blanked", obs, 8'h00);
    apply(8'b0100_1000);
    check("R8 shutdown", obs, 8'b0101_1100);

    // R9: overvoltage
    do_reset();
    apply(8'b1000_0000);
    check("R9 ov set", obs, 8'b1101_1100);
    apply(8'b0000_0000);
    check("R9 ov gone", obs, 8'b0101_1100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule